// File: doc/BRIEF.md
# Programmable Address-Region Select with Automatic Bus Acknowledge

This block decodes a single address region on a 68000-style asynchronous bus. It watches the fifteen most significant address lines and compares a programmable number of them, counted downward from the top line, against a stored base. On a match it drives an active-low select to the addressed device. If the region is set up for it, the block also returns the active-low transfer acknowledge on its own after a programmable number of wait states. Otherwise the addressed device is left to acknowledge the cycle itself.

Three fields are loaded together through a one-cycle write strobe: the region base, a 4-bit span that sets how many high-order bits are compared, and a 4-bit wait code. The block handles indivisible read-modify-write cycles. In these the address strobe stays low through both halves, and a change of direction restarts the wait count. The write half therefore gets the same wait states as an ordinary write.

Top module: `csel_region`

## Requirements
- R1: Synchronous reset sets base to 0, span to 0 and wait code to 15. One cycle with `cfg_we` high loads `cfg_base`, `cfg_span` and `cfg_wait` together, and the new values take effect from the next clock edge.
- R2: With span value n (0..15), address bits `addr_hi[14]` down to `addr_hi[15-n]` must equal the same base bits for a match, where `addr_hi[14]` is the top address line. Span 0 compares nothing, and span 15 compares all fifteen bits.
- R3: If any base bit outside the compared span is 1, the region never matches.
- R4: `cs_n` is high before the first rising clock edge at which `as_n` is low and the address matches. It is low from that edge on while `as_n` stays low, and it stays high for a cycle whose address does not match.
- R5: When `as_n` goes high, `cs_n` and `ack_n` go high in the same cycle, without waiting for a clock edge.
- R6: For wait codes 0 to 14, `ack_n` goes low exactly that many clocks after `cs_n` goes low. It then stays low until `as_n` rises, provided `rw` and the configuration do not change.
- R7: With wait code 15 the block never drives `ack_n` low.
- R8: If `rw` changes while `as_n` stays low in a selected cycle, `ack_n` goes high at once. The wait count restarts at the next edge, so `ack_n` returns low exactly wait-code clocks after that edge.
- R9: `ack_n` is low only while `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_hi | input | 15 | Upper address lines; bit 14 is the top line |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | Direction: 1 = read, 0 = write |
| cfg_we | input | 1 | Loads all three configuration fields |
| cfg_base | input | 15 | Region base, aligned like `addr_hi` |
| cfg_span | input | 4 | Number of compared high-order bits |
| cfg_wait | input | 4 | Wait states 0..14, or 15 for an external acknowledge |
| cs_n | output | 1 | Region select, active low |
| ack_n | output | 1 | Automatic transfer acknowledge, active low |

## Verification
The assertions run on every cycle and cover the relations between the strobe and the outputs. Both outputs are released as soon as the strobe rises, and an acknowledge never appears without a select. An acknowledge is never driven while the wait code is 15, and it is never driven in the cycle in which the direction flips. A select can only begin after the strobe has been low at an edge. Once asserted, an acknowledge holds until the strobe, direction or configuration changes. Only the bench scenarios can show that a given span and base pattern decodes correctly. The same holds for the exact wait-state latency of each code and for the restarted count of the write half of an indivisible cycle.

// File: rtl/csel_pkg.sv
package csel_pkg;

    parameter int ADDR_W  = 15;
    parameter int FIELD_W = 4;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [FIELD_W-1:0] field_t;

    // Wait code that hands the acknowledge to the addressed device
    localparam field_t WAIT_EXTERNAL = '1;

    typedef struct packed {
        addr_t  base;
        field_t span;
        field_t wstates;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{base: '0, span: '0, wstates: WAIT_EXTERNAL};

    // Mask of compared bits: the top `span` positions are set
    function automatic addr_t span_mask(input field_t span);
        addr_t m;
        for (int i = 0; i < ADDR_W; i++) begin
            m[i] = ((ADDR_W - 1 - i) < int'(span));
        end
        return m;
    endfunction

endpackage

// File: rtl/csel_cfg.sv
module csel_cfg
    import csel_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  cfg_t   wr_data,
    output cfg_t   cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (we) begin
            cfg <= wr_data;
        end
    end

endmodule

// File: rtl/csel_match.sv
module csel_match
    import csel_pkg::*;
(
    input  addr_t  addr,
    input  addr_t  base,
    input  field_t span,
    output logic   hit
);

    addr_t mask;
    addr_t diff;
    logic  care_ok;
    logic  dont_care_ok;

    always_comb begin
        mask         = span_mask(span);
        diff         = addr ^ base;
        care_ok      = ~|(diff & mask);
        dont_care_ok = ~|(base & ~mask);
        hit          = care_ok & dont_care_ok;
    end

endmodule

// File: rtl/csel_cycle.sv
module csel_cycle
    import csel_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   as_n,
    input  logic   rw,
    input  logic   hit,
    input  field_t wstates,
    output logic   sel,
    output logic   ack
);

    typedef struct packed {
        logic   active;
        logic   rw_q;
        field_t cnt;
    } cyc_t;

    cyc_t st;
    logic auto_en;
    logic dir_flip;

    assign auto_en  = (wstates != WAIT_EXTERNAL);
    assign dir_flip = (rw != st.rw_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{active: 1'b0, rw_q: 1'b1, cnt: '0};
        end else begin
            st.rw_q <= rw;
            if (as_n) begin
                st.active <= 1'b0;
                st.cnt    <= '0;
            end else if (!st.active) begin
                st.active <= hit;
                st.cnt    <= '0;
            end else if (dir_flip) begin
                st.cnt    <= '0;
            end else if (st.cnt != wstates) begin
                st.cnt    <= st.cnt + 1'b1;
            end
        end
    end

    always_comb begin
        sel = st.active & ~as_n;
        ack = sel & auto_en & (st.cnt == wstates) & ~dir_flip;
    end

endmodule

// File: rtl/csel_region.sv
module csel_region
    import csel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_hi,
    input  logic              as_n,
    input  logic              rw,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [FIELD_W-1:0] cfg_span,
    input  logic [FIELD_W-1:0] cfg_wait,
    output logic              cs_n,
    output logic              ack_n
);

    cfg_t   cfg_in;
    cfg_t   cfg_q;
    logic   hit;
    logic   sel;
    logic   ack;
    field_t ws_cur;

    assign cfg_in = '{base: cfg_base, span: cfg_span, wstates: cfg_wait};
    assign ws_cur = cfg_q.wstates;

    csel_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wr_data (cfg_in),
        .cfg     (cfg_q)
    );

    csel_match u_match (
        .addr (addr_hi),
        .base (cfg_q.base),
        .span (cfg_q.span),
        .hit  (hit)
    );

    csel_cycle u_cycle (
        .clk     (clk),
        .rst     (rst),
        .as_n    (as_n),
        .rw      (rw),
        .hit     (hit),
        .wstates (cfg_q.wstates),
        .sel     (sel),
        .ack     (ack)
    );

    assign cs_n  = ~sel;
    assign ack_n = ~ack;

endmodule

// File: rtl/csel_region_chk.sv
module csel_region_chk
    import csel_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   as_n,
    input logic   rw,
    input logic   cfg_we,
    input logic   cs_n,
    input logic   ack_n,
    input field_t ws
);

    // R5
    strobe_release_chk: assert property (@(posedge clk) disable iff (rst)
        as_n |-> (cs_n && ack_n));

    // R9
    ack_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_n |-> !cs_n);

    // R7
    external_ack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ws == WAIT_EXTERNAL) |-> ack_n);

    // R8
    dir_flip_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!as_n && (rw != $past(rw))) |-> ack_n);

    // R4
    select_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $past(!as_n));

    // R6
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && !cfg_we) |=> (as_n || (rw != $past(rw)) || !ack_n));

endmodule

bind csel_region csel_region_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .as_n   (as_n),
    .rw     (rw),
    .cfg_we (cfg_we),
    .cs_n   (cs_n),
    .ack_n  (ack_n),
    .ws     (ws_cur)
);

// File: tb/csel_region_tb.sv
module csel_region_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] addr_hi = '0;
    logic        as_n = 1'b1;
    logic        rw = 1'b1;
    logic        cfg_we = 1'b0;
    logic [14:0] cfg_base = '0;
    logic [3:0]  cfg_span = '0;
    logic [3:0]  cfg_wait = '0;
    logic        cs_n;
    logic        ack_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    csel_region u_dut (
        .clk(clk), .rst(rst), .addr_hi(addr_hi), .as_n(as_n), .rw(rw),
        .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_span(cfg_span),
        .cfg_wait(cfg_wait), .cs_n(cs_n), .ack_n(ack_n)
    );

    // {span[38:35], wait[34:31], base[30:16], addr[15:1], hit[0]}
    localparam logic [38:0] VEC [8] = '{
        {4'd15, 4'd0,  15'h1234, 15'h1234, 1'b1},  // R2 full compare
        {4'd15, 4'd3,  15'h1234, 15'h1235, 1'b0},  // R2 lowest bit differs
        {4'd1,  4'd2,  15'h4000, 15'h7fff, 1'b1},  // R2 top line only
        {4'd1,  4'd2,  15'h4001, 15'h4001, 1'b0},  // R3 stray base bit
        {4'd0,  4'd5,  15'h0000, 15'h2aaa, 1'b1},  // R2 nothing compared
        {4'd4,  4'd14, 15'h5000, 15'h57ff, 1'b1},  // R6 longest wait
        {4'd4,  4'd1,  15'h5000, 15'h5800, 1'b0},  // R2 fourth bit differs
        {4'd8,  4'd15, 15'h7f80, 15'h7fff, 1'b1}   // R7 external ack
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic configure(input logic [3:0] sp, input logic [3:0] ws, input logic [14:0] b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_span = sp; cfg_wait = ws; cfg_base = b;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Counts negedges from strobe fall until ack_n low; 0 if none within 20
    task automatic bus_cycle(input logic [14:0] a, input logic dir, input logic exp_hit,
                             output int lat);
        @(negedge clk);
        addr_hi = a; rw = dir; as_n = 1'b0;
        #1;
        check("R4 select not before edge", int'(cs_n), 1);
        lat = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (i == 1) check("R4 select after edge", int'(cs_n), exp_hit ? 0 : 1);
            if (!ack_n && lat == 0) lat = i;
        end
    endtask

    task automatic release_strobe();
        as_n = 1'b1;
        #1;
        check("R5 select released", int'(cs_n), 1);
        check("R5 ack released", int'(ack_n), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset select idle", int'(cs_n), 1);
        check("R1 reset ack idle", int'(ack_n), 1);

        // R1: reset config matches everything (span 0, base 0) but gives no ack
        bus_cycle(15'h6abc, 1'b1, 1'b1, lat);
        check("R1 R7 reset wait code external", lat, 0);
        release_strobe();

        for (int v = 0; v < 8; v++) begin
            logic [3:0] sp, ws;
            logic [14:0] b, a;
            logic h;
            {sp, ws, b, a, h} = VEC[v];
            configure(sp, ws, b);
            bus_cycle(a, 1'b1, h, lat);
            if (!h || ws == 4'd15)
                check("R7 R9 no ack", lat, 0);
            else
                check("R6 ack latency", lat, int'(ws) + 1);
            @(negedge clk);
            if (h && ws != 4'd15) check("R6 ack held", int'(ack_n), 0);
            release_strobe();
        end

        // R1: write strobe is needed; values on cfg_* alone do nothing
        configure(4'd15, 4'd2, 15'h0100);
        @(negedge clk);
        cfg_base = 15'h0200; cfg_wait = 4'd0;
        bus_cycle(15'h0100, 1'b1, 1'b1, lat);
        check("R1 config unchanged without strobe", lat, 3);
        release_strobe();

        // R8: indivisible cycle, read then write with wait 3
        configure(4'd15, 4'd3, 15'h0100);
        bus_cycle(15'h0100, 1'b1, 1'b1, lat);
        check("R8 read half latency", lat, 4);
        @(negedge clk);
        rw = 1'b0;
        #1;
        check("R8 ack dropped on direction change", int'(ack_n), 1);
        check("R8 select kept", int'(cs_n), 0);
        lat = 0;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (!ack_n && lat == 0) lat = i;
        end
        check("R8 write half latency", lat, 4);
        release_strobe();

        // R8: zero-wait indivisible cycle
        configure(4'd15, 4'd0, 15'h0100);
        bus_cycle(15'h0100, 1'b1, 1'b1, lat);
        check("R6 zero wait", lat, 1);
        @(negedge clk);
        rw = 1'b0;
        #1;
        check("R8 zero wait drop", int'(ack_n), 1);
        @(negedge clk);
        check("R8 zero wait write ack", int'(ack_n), 0);
        release_strobe();
        rw = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule